// File: doc/BRIEF.md
# Dual-Role Sixteen-Entry Register File

This block holds the sixteen general registers of a small load/store processor core. Its data width is a parameter, normally 32 or 64 bits. It offers two combinational read ports and one synchronous write port. A dedicated link input deposits a return address into register 14 when a call instruction retires. Every port carries a 4-bit register index and a 2-bit role tag. The tag tells the file which instruction field produced the index, because register 15 means different things in different fields.

When a source field that is allowed to name the constant zero selects register 15, the read yields zero. Any other field that selects register 15 (destination, plain source or stack-pointer field) reaches the stack pointer stored there. A store instruction's destination field holds its pointer register, so a read port accepts the destination role and returns the register contents. A write issued in the same cycle as a read of the same register is forwarded to the read data. The decoder, ALU and memory path sit outside this block.

Top module: `dual_role_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register, including register 15, to zero.
- R2: When `wr_en` is high and `link_en` is low, `wr_data` is stored in register `wr_idx` at the clock edge and stays readable afterwards.
- R3: The two read ports are independent and combinational. Each returns the register named by its own index in the same cycle.
- R4: A read whose role is zero-source (encoding 2'b10) and whose index is 15 returns zero, whatever the stack pointer holds.
- R5: A read of index 15 with the destination (2'b00), source (2'b01) or stack-pointer (2'b11) role returns the stored stack pointer.
- R6: A read of the register being written in the same cycle returns the new write data, unless R4 applies.
- R7: When `link_en` is high, `link_data` is stored in register 14 at the clock edge.
- R8: When `link_en` and `wr_en` are both high, only the link write takes effect. The ordinary write is discarded and is not forwarded.
- R9: A write whose role is zero-source and whose index is 15 is discarded. The stack pointer keeps its value and nothing is forwarded.
- R10: A zero-source read of any index below 15 returns that register's contents.
- R11: A read with the destination role returns the register contents, so a store's pointer register can be fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_role | input | 2 | Read port A role tag |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_role | input | 2 | Read port B role tag |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Ordinary write enable |
| wr_idx | input | 4 | Write register index |
| wr_role | input | 2 | Write role tag |
| wr_data | input | DATA_W | Write data |
| link_en | input | 1 | Link write enable (targets register 14) |
| link_data | input | DATA_W | Return address to store in register 14 |

## Verification
The assertions assume that every input is a known value on each sampled edge, and that the role tags use only the four defined encodings. They also assume that reset is held for at least one edge before any write. The stimulus holds every input at zero under reset and drives only defined role codes. It changes inputs on the falling edge, so the values are settled when the rising edge samples them. It deliberately raises `link_en` together with `wr_en`, which a real decoder would never do, so that the priority rule of R8 is exercised.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int NUM_REGS  = 16;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int LINK_REG  = 14;
    localparam int STACK_REG = 15;

    typedef logic [IDX_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        ROLE_DEST  = 2'b00,
        ROLE_SRC   = 2'b01,
        ROLE_ZSRC  = 2'b10,
        ROLE_STACK = 2'b11
    } slot_role_e;

    // Register 15 named from the zero-capable field acts as a constant-zero slot.
    function automatic logic hits_zero_slot(input reg_idx_t idx, input logic [1:0] role);
        return (role == ROLE_ZSRC) && (idx == reg_idx_t'(STACK_REG));
    endfunction

endpackage

// File: rtl/rf_write_arb.sv
module rf_write_arb
    import regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              wr_en,
    input  reg_idx_t          wr_idx,
    input  logic [1:0]        wr_role,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    input  logic [DATA_W-1:0] link_data,
    output logic              commit_en,
    output reg_idx_t          commit_idx,
    output logic [DATA_W-1:0] commit_data
);

    logic ordinary_ok;

    assign ordinary_ok = wr_en && !hits_zero_slot(wr_idx, wr_role);

    always_comb begin
        if (link_en) begin
            commit_en   = 1'b1;
            commit_idx  = reg_idx_t'(LINK_REG);
            commit_data = link_data;
        end else begin
            commit_en   = ordinary_ok;
            commit_idx  = wr_idx;
            commit_data = wr_data;
        end
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_en,
    input  reg_idx_t          commit_idx,
    input  logic [DATA_W-1:0] commit_data,
    output logic [DATA_W-1:0] regs [NUM_REGS]
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (commit_en && (commit_idx == reg_idx_t'(g))) begin
                regs[g] <= commit_data;
            end
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  reg_idx_t          rd_idx,
    input  logic [1:0]        rd_role,
    input  logic [DATA_W-1:0] regs [NUM_REGS],
    input  logic              commit_en,
    input  reg_idx_t          commit_idx,
    input  logic [DATA_W-1:0] commit_data,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        if (hits_zero_slot(rd_idx, rd_role)) begin
            rd_data = '0;
        end else if (commit_en && (commit_idx == rd_idx)) begin
            rd_data = commit_data;
        end else begin
            rd_data = regs[rd_idx];
        end
    end

endmodule

// File: rtl/dual_role_regfile.sv
module dual_role_regfile
    import regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        rd_a_idx,
    input  logic [1:0]        rd_a_role,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    input  logic [1:0]        rd_b_role,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [1:0]        wr_role,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    input  logic [DATA_W-1:0] link_data
);

    localparam int NUM_PORTS = 2;

    logic              commit_en;
    reg_idx_t          commit_idx;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] regs [NUM_REGS];

    reg_idx_t          port_idx  [NUM_PORTS];
    logic [1:0]        port_role [NUM_PORTS];
    logic [DATA_W-1:0] port_data [NUM_PORTS];

    assign port_idx[0]  = rd_a_idx;
    assign port_role[0] = rd_a_role;
    assign port_idx[1]  = rd_b_idx;
    assign port_role[1] = rd_b_role;
    assign rd_a_data    = port_data[0];
    assign rd_b_data    = port_data[1];

    rf_write_arb #(.DATA_W(DATA_W)) u_arb (
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_role     (wr_role),
        .wr_data     (wr_data),
        .link_en     (link_en),
        .link_data   (link_data),
        .commit_en   (commit_en),
        .commit_idx  (commit_idx),
        .commit_data (commit_data)
    );

    rf_storage #(.DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .commit_en   (commit_en),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .regs        (regs)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rf_read_port #(.DATA_W(DATA_W)) u_rd (
            .rd_idx      (port_idx[p]),
            .rd_role     (port_role[p]),
            .regs        (regs),
            .commit_en   (commit_en),
            .commit_idx  (commit_idx),
            .commit_data (commit_data),
            .rd_data     (port_data[p])
        );
    end

endmodule

// File: rtl/regfile_checker.sv
module regfile_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        rd_a_idx,
    input logic [1:0]        rd_a_role,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [3:0]        rd_b_idx,
    input logic [1:0]        rd_b_role,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [1:0]        wr_role,
    input logic [DATA_W-1:0] wr_data,
    input logic              link_en,
    input logic [DATA_W-1:0] link_data
);

    logic a_zero, b_zero, wr_sink, plain_wr;
    assign a_zero   = (rd_a_role == 2'b10) && (rd_a_idx == 4'd15);
    assign b_zero   = (rd_b_role == 2'b10) && (rd_b_idx == 4'd15);
    assign wr_sink  = (wr_role == 2'b10) && (wr_idx == 4'd15);
    assign plain_wr = wr_en && !link_en && !wr_sink;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_en && !link_en) |-> (rd_a_data == '0 && rd_b_data == '0)); // R1

    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && wr_en && !link_en && !wr_sink) && rd_a_idx == $past(wr_idx)
         && !a_zero && !link_en && !wr_en) |-> rd_a_data == $past(wr_data)); // R2

    AST_ZERO_SLOT: assert property (@(posedge clk) disable iff (rst)
        (a_zero |-> rd_a_data == '0) and (b_zero |-> rd_b_data == '0)); // R4

    AST_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (plain_wr && wr_idx == rd_b_idx && !b_zero) |-> rd_b_data == wr_data); // R6

    AST_LINK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && link_en) && rd_a_idx == 4'd14 && !a_zero && !link_en && !wr_en)
        |-> rd_a_data == $past(link_data)); // R7

    AST_LINK_WINS: assert property (@(posedge clk) disable iff (rst)
        (link_en && wr_en && rd_b_idx == 4'd14 && rd_b_role != 2'b10)
        |-> rd_b_data == link_data); // R8

endmodule

bind dual_role_regfile regfile_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_a_idx  (rd_a_idx),
    .rd_a_role (rd_a_role),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_role (rd_b_role),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_role   (wr_role),
    .wr_data   (wr_data),
    .link_en   (link_en),
    .link_data (link_data)
);

// File: tb/tb_dual_role_regfile.sv
module tb_dual_role_regfile;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [1:0]    rd_a_role = '0, rd_b_role = '0, wr_role = '0;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic          wr_en = 1'b0, link_en = 1'b0;
    logic [DW-1:0] wr_data = '0, link_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    dual_role_regfile #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_role(rd_a_role), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_role(rd_b_role), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_role(wr_role), .wr_data(wr_data),
        .link_en(link_en), .link_data(link_data)
    );

    localparam logic [1:0] D = 2'b00, S = 2'b01, Z = 2'b10, P = 2'b11;

    typedef struct packed {
        logic          we;
        logic [3:0]    wi;
        logic [1:0]    wr;
        logic [DW-1:0] wd;
        logic          le;
        logic [DW-1:0] ld;
        logic [3:0]    ai;
        logic [1:0]    ar;
        logic [3:0]    bi;
        logic [1:0]    br;
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1, 3,  D, 32'h1111_0003, 0, 0,       3,  S, 4,  S, 32'h1111_0003, 0,             6},  // R6, R1
        '{0, 0,  D, 0,             0, 0,       3,  S, 3,  D, 32'h1111_0003, 32'h1111_0003, 11}, // R2, R3, R11
        '{1, 15, D, 32'h0000_F000, 0, 0,       15, P, 15, Z, 32'h0000_F000, 0,             4},  // R6, R4
        '{0, 0,  D, 0,             0, 0,       15, S, 15, Z, 32'h0000_F000, 0,             5},  // R5, R4
        '{1, 15, Z, 32'h0000_DEAD, 0, 0,       15, P, 15, D, 32'h0000_F000, 32'h0000_F000, 9},  // R9
        '{0, 0,  D, 0,             0, 0,       15, P, 3,  Z, 32'h0000_F000, 32'h1111_0003, 10}, // R9, R10
        '{0, 0,  D, 0,             1, 32'h400, 14, S, 14, Z, 32'h400,       32'h400,       7},  // R7 forwarded
        '{0, 0,  D, 0,             0, 0,       14, D, 0,  S, 32'h400,       0,             7},  // R7
        '{1, 5,  D, 32'h55,        1, 32'h800, 14, S, 5,  S, 32'h800,       0,             8},  // R8
        '{0, 0,  D, 0,             0, 0,       5,  S, 14, S, 0,             32'h800,       8},  // R8
        '{1, 14, D, 32'h777,       1, 32'h999, 14, S, 14, Z, 32'h999,       32'h999,       8},  // R8
        '{0, 0,  D, 0,             0, 0,       14, S, 15, P, 32'h999,       32'h0000_F000, 5},  // R5
        '{1, 0,  D, 32'hFFFF_FFFF, 0, 0,       0,  S, 0,  Z, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 10}  // R10, R6
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; link_en = 0; wr_idx = 0; wr_role = D; wr_data = 0; link_data = 0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: all registers read zero after reset
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i); rd_a_role = S; rd_b_idx = 4'(i); rd_b_role = P;
            #1;
            check("R1", rd_a_data, '0);
            check("R1", rd_b_data, '0);
            @(negedge clk);
        end
        // vector table
        for (int v = 0; v < NV; v++) begin
            wr_en = VECS[v].we; wr_idx = VECS[v].wi; wr_role = VECS[v].wr; wr_data = VECS[v].wd;
            link_en = VECS[v].le; link_data = VECS[v].ld;
            rd_a_idx = VECS[v].ai; rd_a_role = VECS[v].ar;
            rd_b_idx = VECS[v].bi; rd_b_role = VECS[v].br;
            #1;
            check($sformatf("R%0d vec%0d portA", VECS[v].req, v), rd_a_data, VECS[v].ea);
            check($sformatf("R%0d vec%0d portB", VECS[v].req, v), rd_b_data, VECS[v].eb);
            @(negedge clk);
        end
        idle_inputs();
        // R2 / R3: fill all sixteen registers, then read back on both ports
        for (int i = 0; i < 16; i++) begin
            wr_en = 1; wr_idx = 4'(i); wr_role = D; wr_data = 32'hA5A5_0000 + 32'(i);
            @(negedge clk);
        end
        idle_inputs();
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i); rd_a_role = S;
            rd_b_idx = 4'(15 - i); rd_b_role = Z;
            #1;
            check("R2", rd_a_data, 32'hA5A5_0000 + 32'(i));
            check("R3", rd_b_data, (i == 0) ? '0 : 32'hA5A5_0000 + 32'(15 - i)); // R4 at index 15
            @(negedge clk);
        end
        // R1: reset in mid-run clears stack pointer and link register
        rst = 1;
        @(negedge clk);
        rst = 0;
        rd_a_idx = 15; rd_a_role = P; rd_b_idx = 14; rd_b_role = D;
        #1;
        check("R1", rd_a_data, '0);
        check("R1", rd_b_data, '0);
        finish_run();
    end

endmodule